// File: doc/BRIEF.md
# Instruction Single-Step Debug Controller

This block lets an external debugger walk a small sequential processor through its program one instruction at a time. The debugger drives an active-low step request. The block passes it through a two-flop synchronizer and looks at it only when an instruction finishes. When the request is low at that point, the core freezes before its next fetch. The block raises an address-latch-enable style output and holds it high for as long as the core stays stopped. While stopped, it drives the address of the next instruction on a multiplexed bus and on the lower half of a narrow port.

When the debugger drives the request high, the latch-enable output falls and the core runs the fetch machine cycle of the next instruction. If the request is low again by the end of that instruction, the core stops at the following boundary. If the request stays high, the core runs freely.

A compact core model stands in for the processor. It has a program counter, a machine-cycle phase counter, two-cycle instructions at fixed addresses, and a running machine-cycle counter, which serves as its timer. The model also has a bus output buffer that a single-step halt discards.

Top module: `sstep_unit`

## Requirements
- R1: After a synchronous reset, ale_o=0, bus_oe_o=0, bus_o=0, port_o=0 and mcyc_cnt_o=0, and execution starts at address 0. If the request is held low through reset, the first halt shows address 1 with mcyc_cnt_o=1.
- R2: A low step_req_n_i, seen after two synchronizer clocks, stops the core only at the end of an instruction. The stop is acknowledged by ale_o rising.
- R3: An instruction whose address has both low bits set (binary 11) takes two machine cycles, and every other instruction takes one. Both cycles always complete before a halt. At every halt at address P, mcyc_cnt_o equals P + floor(P/4).
- R4: While halted, ale_o stays high with no time limit, and the address, bus and mcyc_cnt_o do not change.
- R5: While halted, bus_oe_o=1 and bus_o holds address bits [BUS_W-1:0]. port_o bits [PORT_W/2-1:0] hold address bits [ADDR_W-1:BUS_W], and the upper half of port_o is 0. ADDR_W is BUS_W+PORT_W/2.
- R6: Driving step_req_n_i high ends the halt, and ale_o falls. If the request is driven low on the clock after ale_o falls, the core stops again at exactly the next address. mcyc_cnt_o then has advanced by the length of the instruction that ran.
- R7: While the request is high, the core runs freely: ale_o stays 0 and mcyc_cnt_o advances by one every CYC_CLKS clocks.
- R8: When bus_we_i is high in a running cycle, the next clock drives bus_wdata_i on bus_o with bus_oe_o=1. Entering a halt discards the buffer, and writes made while halted are dropped. After release, bus_oe_o is 0 until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req_n_i | input | 1 | Active-low step request, asynchronous |
| bus_we_i | input | 1 | Write strobe for the bus output buffer |
| bus_wdata_i | input | BUS_W | Data for the bus output buffer |
| ale_o | output | 1 | High while the core is halted |
| bus_o | output | BUS_W | Buffer data when running, low address bits when halted |
| bus_oe_o | output | 1 | Bus drive enable |
| port_o | output | PORT_W | Upper address bits on the lower half when halted, otherwise 0 |
| mcyc_cnt_o | output | TMR_W | Count of completed machine cycles |

## Verification
Two cases are hard to reach from the ports. The first is a request that arrives during the second machine cycle of a two-cycle instruction. The second is a request that arrives inside the single fetch cycle that follows a release. The bench reaches both by releasing the halt and then holding the request high for a swept number of clocks, from zero to several machine cycles, before lowering it again. It also single-steps through more than three hundred consecutive addresses, which covers every instruction length and the carry into the port bits. At each halt it checks the arithmetic link between the shown address and the cycle count.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_RESUME = 2'd2
  } sstep_state_e;

  // An instruction spans two machine cycles when both address LSBs are set.
  function automatic logic is_two_cycle(input logic [1:0] addr_lsb);
    return &addr_lsb;
  endfunction

endpackage

// File: rtl/sstep_sync.sv
module sstep_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sstep_core.sv
module sstep_core
  import sstep_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CYC_CLKS = 4,
  parameter int TMR_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en_i,
  output logic              mc_end_o,
  output logic              instr_end_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic [TMR_W-1:0]  tmr_o
);
  localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);

  logic [PH_W-1:0]   ph_q;
  logic              second_q;
  logic [ADDR_W-1:0] pc_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              two_cyc;
  logic              mc_end;
  logic              instr_end;
  logic [ADDR_W-1:0] pc_d;

  assign two_cyc   = is_two_cycle(pc_q[1:0]);
  assign mc_end    = run_en_i && (ph_q == PH_LAST);
  assign instr_end = mc_end && (second_q || !two_cyc);
  assign pc_d      = instr_end ? pc_q + ADDR_W'(1) : pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      second_q <= 1'b0;
      pc_q     <= '0;
      tmr_q    <= '0;
    end else if (run_en_i) begin
      ph_q <= mc_end ? '0 : ph_q + PH_W'(1);
      if (mc_end) begin
        second_q <= !second_q && two_cyc;
        tmr_q    <= tmr_q + TMR_W'(1);
        pc_q     <= pc_d;
      end
    end
  end

  assign mc_end_o    = mc_end;
  assign instr_end_o = instr_end;
  assign pc_o        = pc_q;
  assign pc_next_o   = pc_d;
  assign tmr_o       = tmr_q;

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !run_en_i |=> ($stable(pc_q) && $stable(tmr_q)));

  assert_second_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    second_q |-> is_two_cycle(pc_q[1:0]));

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (rst)
    32'(ph_q) < CYC_CLKS);
endmodule

// File: rtl/sstep_fsm.sv
module sstep_fsm
  import sstep_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         req_s_i,
  input  logic         mc_end_i,
  input  logic         instr_end_i,
  output logic         run_en_o,
  output logic         halt_d_o,
  output sstep_state_e state_o
);
  sstep_state_e state_q;
  sstep_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (instr_end_i && !req_s_i) state_d = ST_HALT;
      end
      ST_HALT: begin
        if (req_s_i) state_d = ST_RESUME;
      end
      ST_RESUME: begin
        if (instr_end_i && !req_s_i) state_d = ST_HALT;
        else if (mc_end_i)           state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign run_en_o = (state_q != ST_HALT);
  assign halt_d_o = (state_d == ST_HALT);
  assign state_o  = state_q;

  assert_halt_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_HALT) |-> !$past(req_s_i));

  assert_resume_one_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESUME && !mc_end_i) |=> (state_q == ST_RESUME));

  assert_halt_held_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !req_s_i) |=> (state_q == ST_HALT));
endmodule

// File: rtl/sstep_out.sv
module sstep_out #(
  parameter int BUS_W  = 8,
  parameter int PORT_W = 8,
  parameter int ADDR_W = BUS_W + PORT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_d_i,
  input  logic [ADDR_W-1:0] addr_d_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic              ale_o,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int HI_W = ADDR_W - BUS_W;
  localparam int PAD_W = PORT_W - HI_W;

  logic [BUS_W-1:0]  buf_q, buf_d;
  logic              vld_q, vld_d;
  logic              ale_q, oe_q;
  logic [BUS_W-1:0]  bus_q;
  logic [PORT_W-1:0] port_q;

  always_comb begin
    buf_d = buf_q;
    vld_d = vld_q;
    if (halt_d_i) begin
      buf_d = '0;
      vld_d = 1'b0;
    end else if (bus_we_i) begin
      buf_d = bus_wdata_i;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      vld_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
      bus_q  <= '0;
      port_q <= '0;
    end else begin
      buf_q <= buf_d;
      vld_q <= vld_d;
      ale_q <= halt_d_i;
      if (halt_d_i) begin
        oe_q   <= 1'b1;
        bus_q  <= addr_d_i[BUS_W-1:0];
        port_q <= {{PAD_W{1'b0}}, addr_d_i[ADDR_W-1:BUS_W]};
      end else begin
        oe_q   <= vld_d;
        bus_q  <= vld_d ? buf_d : '0;
        port_q <= '0;
      end
    end
  end

  assign ale_o    = ale_q;
  assign bus_o    = bus_q;
  assign bus_oe_o = oe_q;
  assign port_o   = port_q;

  assert_addr_driven_R5: assert property (@(posedge clk) disable iff (rst)
    ale_q |-> oe_q);

  assert_port_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    port_q[PORT_W-1:HI_W] == '0);

  assert_buffer_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_q) |-> (!oe_q || $past(bus_we_i)));
endmodule

// File: rtl/sstep_unit.sv
module sstep_unit
  import sstep_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int PORT_W   = 8,
  parameter int CYC_CLKS = 4,
  parameter int TMR_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_req_n_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic              ale_o,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic [PORT_W-1:0] port_o,
  output logic [TMR_W-1:0]  mcyc_cnt_o
);
  localparam int ADDR_W = BUS_W + PORT_W / 2;

  logic              req_s;
  logic              run_en;
  logic              halt_d;
  logic              mc_end;
  logic              instr_end;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  sstep_state_e      state;

  sstep_sync #(.RST_VAL(1'b1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (step_req_n_i),
    .q_o (req_s)
  );

  sstep_core #(
    .ADDR_W  (ADDR_W),
    .CYC_CLKS(CYC_CLKS),
    .TMR_W   (TMR_W)
  ) i_core (
    .clk        (clk),
    .rst        (rst),
    .run_en_i   (run_en),
    .mc_end_o   (mc_end),
    .instr_end_o(instr_end),
    .pc_o       (pc_q),
    .pc_next_o  (pc_d),
    .tmr_o      (mcyc_cnt_o)
  );

  sstep_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_s_i    (req_s),
    .mc_end_i   (mc_end),
    .instr_end_i(instr_end),
    .run_en_o   (run_en),
    .halt_d_o   (halt_d),
    .state_o    (state)
  );

  sstep_out #(
    .BUS_W (BUS_W),
    .PORT_W(PORT_W),
    .ADDR_W(ADDR_W)
  ) i_out (
    .clk        (clk),
    .rst        (rst),
    .halt_d_i   (halt_d),
    .addr_d_i   (pc_d),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .ale_o      (ale_o),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .port_o     (port_o)
  );

  assert_halt_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ale_o) |-> $past(instr_end));

  assert_exit_on_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_o) |-> $past(req_s));

  assert_halted_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && ale_o) |-> (bus_o == pc_q[BUS_W-1:0]));
endmodule

// File: tb/test_sstep_unit.sv
module test_sstep_unit;
  localparam int BW = 8;
  localparam int PW = 8;
  localparam int CC = 4;
  localparam int TW = 16;
  localparam int HW = PW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_n = 1'b1;
  logic          we = 1'b0;
  logic [BW-1:0] wd = '0;
  logic          ale;
  logic [BW-1:0] bus;
  logic          oe;
  logic [PW-1:0] port;
  logic [TW-1:0] tmr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sstep_unit #(.BUS_W(BW), .PORT_W(PW), .CYC_CLKS(CC), .TMR_W(TW)) i_sstep_unit (
    .clk(clk), .rst(rst), .step_req_n_i(req_n), .bus_we_i(we), .bus_wdata_i(wd),
    .ale_o(ale), .bus_o(bus), .bus_oe_o(oe), .port_o(port), .mcyc_cnt_o(tmr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int addr_now();
    return int'({port[HW-1:0], bus});
  endfunction

  function automatic int ilen(input int a);
    return ((a % 4) == 3) ? 2 : 1;
  endfunction

  task automatic wait_ale(input logic v, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ale == v) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, tag, longint'(ale), longint'(v));
  endtask

  task automatic do_reset(input logic hold_req);
    @(negedge clk);
    rst = 1'b1;
    req_n = hold_req;
    repeat (5 * CC + 2) @(negedge clk);
    rst = 1'b0;
    chk(ale == 1'b0 && oe == 1'b0 && bus == '0 && port == '0 && tmr == '0,
        "R1 reset outputs", longint'({ale, oe, bus, port}), 0);
  endtask

  task automatic check_halt_relation(input string tag);
    int p;
    p = addr_now();
    chk(int'(tmr) == p + p / 4, tag, longint'(tmr), longint'(p + p / 4));
    chk(oe == 1'b1 && port[PW-1:HW] == '0, "R5 halted bus drive", longint'({oe, port}), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int t0, p0, t1, p1, bad;
    do_reset(1'b1);

    // R7: free run, ale stays low, counter rate
    bad = 0;
    @(negedge clk);
    t0 = int'(tmr);
    for (int i = 0; i < 10 * CC; i++) begin
      @(negedge clk);
      if (ale) bad++;
    end
    chk(bad == 0, "R7 ale low while running", bad, 0);
    chk(int'(tmr) - t0 == 10, "R7 machine cycle rate", int'(tmr) - t0, 10);

    // R8: buffer write during run
    we = 1'b1; wd = 8'h3C;
    @(negedge clk);
    we = 1'b0;
    chk(oe == 1'b1 && bus == 8'h3C, "R8 buffer drives bus", longint'(bus), 8'h3C);
    @(negedge clk);
    chk(oe == 1'b1 && bus == 8'h3C, "R8 buffer held", longint'(bus), 8'h3C);

    // R2/R3/R5: halt
    req_n = 1'b0;
    wait_ale(1'b1, "R2 halt acknowledged");
    check_halt_relation("R3 halt on boundary");

    // R4: indefinite halt
    p0 = addr_now(); t0 = int'(tmr); bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!ale || addr_now() != p0 || int'(tmr) != t0) bad++;
    end
    chk(bad == 0, "R4 frozen while halted", bad, 0);

    // R8: write while halted is dropped
    we = 1'b1; wd = 8'h77;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk(addr_now() == p0 && oe == 1'b1, "R8 halted write ignored", addr_now(), p0);

    // R6/R3: step sweep across many addresses
    for (int s = 0; s < 300; s++) begin
      p0 = addr_now(); t0 = int'(tmr);
      req_n = 1'b1;
      wait_ale(1'b0, "R6 release");
      if (s == 0) chk(oe == 1'b0, "R8 buffer discarded", longint'(oe), 0);
      req_n = 1'b0;
      wait_ale(1'b1, "R6 re-halt");
      p1 = addr_now(); t1 = int'(tmr);
      chk(p1 == p0 + 1, "R6 single step address", p1, p0 + 1);
      chk(t1 - t0 == ilen(p0), "R3 step cycle count", t1 - t0, ilen(p0));
      chk(port[PW-1:HW] == '0 && oe == 1'b1, "R5 port upper zero", longint'(port), longint'(port[HW-1:0]));
    end

    // R2/R3: sweep request arrival offset after release
    for (int off = 0; off < 6 * CC; off++) begin
      req_n = 1'b1;
      wait_ale(1'b0, "R6 release sweep");
      repeat (off + 3) @(negedge clk);
      req_n = 1'b0;
      wait_ale(1'b1, "R2 halt sweep");
      check_halt_relation("R3 sweep boundary");
    end

    // R1: reset with request held low halts after first instruction
    do_reset(1'b0);
    wait_ale(1'b1, "R1 halt after reset");
    chk(addr_now() == 1 && int'(tmr) == 1, "R1 first halt address", addr_now(), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule